// File: doc/BRIEF.md
# Shared Fractional-Delay Skew Corrector for an Interleaved Converter Stream

The block sits on the merged output of a multi-channel time-interleaved converter and removes the sampling-instant skew of each sub-channel. Every incoming sample carries the index of the channel that produced it. The block picks that channel's skew word and applies a third-order Lagrange fractional-delay interpolation with that skew, using a four-sample history shared by all channels. Channel 0 is the timing reference and always passes through unchanged.

The interpolator uses a polynomial-in-skew structure. Four fixed FIR sub-filters run in parallel on the same history, one for each power of the skew. A three-stage Horner chain then multiplies by the skew and adds the next sub-filter output. The skew value travels down the pipeline with its sample, so the skew can change on every sample without a flush. The corrected result is rounded, clamped to the input range and presented with a valid strobe a fixed number of clocks later. The skew words come from an estimator outside this block.

Top module: `skew_farrow_corrector`

## Requirements
- R1: `out_valid` is high exactly 4 clock edges after the edge at which `in_valid` was sampled high, and is low otherwise.
- R2: A sample whose `in_chan` is 0 uses a skew of zero, whatever `alpha_flat[15:0]` holds. Its output equals the input sample exactly.
- R3: A sample from channel c (c = 1..3) uses the skew word `alpha_flat[c*16 +: 16]`. This word is a signed two's-complement value with 15 fractional bits, so its range is -1 to just under +1. Consecutive samples may use different skew words.
- R4: Let x0 be the new sample and x1..x3 the three earlier valid samples. Each sub-filter output is s_k = Σ q_kj·x_j, where q_kj is the tap weight times 2^15, rounded half away from zero. The tap weights are s0: [1,0,0,0], s1: [-11/6, 3, -3/2, 1/3], s2: [1, -5/2, 2, -1/2] and s3: [-1/6, 1/2, -1/2, 1/6]. The chain then computes a = s3, and for k = 2, 1, 0 in turn a = s_k + floor(a·α / 2^15).
- R5: The result before clamping is floor((a + 2^14) / 2^15), which rounds half up.
- R6: Results above 127 are output as 127, and results below -128 are output as -128.
- R7: The sample history advances only on valid samples. Idle cycles between samples do not change any result.
- R8: While `out_valid` is low, `out_data` keeps the last corrected value.
- R9: During and after reset, `out_valid` is 0 and `out_data` is 0. The history starts at all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Input sample, signed |
| in_chan | input | 2 | Channel that produced the sample |
| alpha_flat | input | 64 | Per-channel skew words, 16 bits each, channel c at bits c*16 and up |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 8 | Corrected sample, signed |

## Verification
The hardest situation to reach is a sample whose skew differs from the skew of the samples still inside the Horner chain. Only then does a skew that failed to travel with its data give a wrong answer. The stimulus therefore feeds channels round-robin, with a different nonzero skew on each channel and a nonzero word on the reference slot, so that every stage holds a different skew on every cycle. Clamping is reached by arranging a step in the history and giving the channel that completes it a skew of one half. That makes the interpolation overshoot in both directions.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAC_W  = 15;
    localparam int COEF_W  = 18;
    localparam int ALPHA_W = FRAC_W + 1;
    localparam int TAPS    = 4;
    localparam int ORDER   = TAPS - 1;
    localparam int ACC_W   = COEF_W + DATA_W + 2;
    localparam int PROD_W  = ACC_W + ALPHA_W;

    typedef logic signed [DATA_W-1:0]  sample_t;
    typedef logic signed [COEF_W-1:0]  coef_t;
    typedef logic signed [ALPHA_W-1:0] alpha_t;
    typedef logic signed [ACC_W-1:0]   acc_t;

    // one pipeline slot: strobe, skew of this sample, sub-filter outputs, running Horner value
    typedef struct packed {
        logic                vld;
        alpha_t              alpha;
        acc_t [TAPS-1:0]     sub;
        acc_t                acc;
    } stage_t;

    // Lagrange tap weight for power k of the skew on tap j, quantized to FRAC_W fraction bits
    function automatic coef_t coef_q(input int k, input int j);
        int     num;
        int     den;
        longint v;
        longint r;
        case (k * TAPS + j)
            0:       begin num = 1;   den = 1; end
            4:       begin num = -11; den = 6; end
            5:       begin num = 3;   den = 1; end
            6:       begin num = -3;  den = 2; end
            7:       begin num = 1;   den = 3; end
            8:       begin num = 1;   den = 1; end
            9:       begin num = -5;  den = 2; end
            10:      begin num = 2;   den = 1; end
            11:      begin num = -1;  den = 2; end
            12:      begin num = -1;  den = 6; end
            13:      begin num = 1;   den = 2; end
            14:      begin num = -1;  den = 2; end
            15:      begin num = 1;   den = 6; end
            default: begin num = 0;   den = 1; end
        endcase
        v = longint'(num) <<< FRAC_W;
        if (v >= 0) r = (v + longint'(den / 2)) / longint'(den);
        else        r = -((-v + longint'(den / 2)) / longint'(den));
        return coef_t'(r);
    endfunction

endpackage

// File: rtl/sfc_front.sv
module sfc_front
    import sfc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  sample_t                   in_data,
    input  logic [CH_W-1:0]           in_chan,
    input  logic [NUM_CH*ALPHA_W-1:0] alpha_flat,
    output stage_t                    out_p
);

    typedef struct packed {
        sample_t [TAPS-2:0] hist;
        stage_t             pipe;
    } front_t;

    front_t  front_d, front_q;
    sample_t taps [TAPS];
    acc_t    sub_w [TAPS];
    alpha_t  alpha_sel;

    always_comb begin
        front_d      = front_q;
        front_d.pipe.vld = in_valid;

        taps[0] = in_data;
        for (int j = 1; j < TAPS; j++) begin
            taps[j] = front_q.hist[j-1];
        end

        for (int k = 0; k < TAPS; k++) begin
            sub_w[k] = '0;
            for (int j = 0; j < TAPS; j++) begin
                sub_w[k] = sub_w[k] + acc_t'(coef_q(k, j)) * acc_t'($signed(taps[j]));
            end
        end

        // reference channel runs with zero skew
        if (in_chan == '0) alpha_sel = '0;
        else               alpha_sel = alpha_flat[in_chan*ALPHA_W +: ALPHA_W];

        if (in_valid) begin
            front_d.pipe.alpha = alpha_sel;
            for (int k = 0; k < TAPS; k++) begin
                front_d.pipe.sub[k] = sub_w[k];
            end
            front_d.pipe.acc = sub_w[TAPS-1];
            front_d.hist[0]  = in_data;
            for (int j = 1; j < TAPS-1; j++) begin
                front_d.hist[j] = front_q.hist[j-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) front_q <= '0;
        else        front_q <= front_d;
    end

    assign out_p = front_q.pipe;

    p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> front_q.hist[0] == $past(in_data));

    p_hist_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(front_q.hist));

    p_ref_alpha_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_chan == '0) |=> out_p.alpha == '0);

endmodule

// File: rtl/sfc_horner_stage.sv
module sfc_horner_stage
    import sfc_pkg::*;
#(
    parameter int STEP = 0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t in_p,
    output stage_t out_p
);

    localparam int ADD_IDX = TAPS - 2 - STEP;

    stage_t                    stage_d, stage_q;
    logic signed [PROD_W-1:0]  prod;
    acc_t                      scaled;

    always_comb begin
        prod    = PROD_W'($signed(in_p.acc)) * PROD_W'($signed(in_p.alpha));
        scaled  = acc_t'(prod >>> FRAC_W);
        stage_d = stage_q;
        stage_d.vld = in_p.vld;
        if (in_p.vld) begin
            stage_d     = in_p;
            stage_d.acc = in_p.sub[ADD_IDX] + scaled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_p = stage_q;

    p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_p.vld |=> $stable(stage_q.acc));

    p_stage_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_p.vld |=> stage_q.vld);

    p_stage_alpha_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_p.vld |=> stage_q.alpha == $past(in_p.alpha));

endmodule

// File: rtl/sfc_round_sat.sv
module sfc_round_sat
    import sfc_pkg::*;
(
    input  acc_t    acc,
    output sample_t y
);

    localparam acc_t HALF  = acc_t'(1) <<< (FRAC_W - 1);
    localparam acc_t S_MAX = acc_t'(2 ** (DATA_W - 1) - 1);
    localparam acc_t S_MIN = -acc_t'(2 ** (DATA_W - 1));

    acc_t rounded;

    always_comb begin
        rounded = (acc + HALF) >>> FRAC_W;
        if (rounded > S_MAX)      y = sample_t'(S_MAX);
        else if (rounded < S_MIN) y = sample_t'(S_MIN);
        else                      y = sample_t'(rounded);
    end

endmodule

// File: rtl/skew_farrow_corrector.sv
module skew_farrow_corrector
    import sfc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic signed [DATA_W-1:0]         in_data,
    input  logic [CH_W-1:0]                  in_chan,
    input  logic [NUM_CH*ALPHA_W-1:0]        alpha_flat,
    output logic                             out_valid,
    output logic signed [DATA_W-1:0]         out_data
);

    localparam int LATENCY = ORDER + 1;
    localparam int WARM_W  = $clog2(LATENCY + 1);

    stage_t pipe_w [ORDER+1];

    sfc_front #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_chan    (in_chan),
        .alpha_flat (alpha_flat),
        .out_p      (pipe_w[0])
    );

    for (genvar g = 0; g < ORDER; g++) begin : g_horner
        sfc_horner_stage #(
            .STEP (g)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .in_p  (pipe_w[g]),
            .out_p (pipe_w[g+1])
        );
    end

    sfc_round_sat u_round (
        .acc (pipe_w[ORDER].acc),
        .y   (out_data)
    );

    assign out_valid = pipe_w[ORDER].vld;

    // cycles since reset, saturating, so latency checks never look before reset
    logic [WARM_W-1:0] warm_d, warm_q;

    always_comb begin
        warm_d = warm_q;
        if (warm_q != WARM_W'(LATENCY)) warm_d = warm_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == WARM_W'(LATENCY)) |-> out_valid == $past(in_valid, 4));

    p_zero_skew_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pipe_w[ORDER].alpha == '0)
            |-> out_data == DATA_W'($signed(pipe_w[ORDER].sub[0]) >>> FRAC_W));

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/skew_farrow_corrector_tb.sv
module skew_farrow_corrector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic signed [7:0] in_data = '0;
    logic [1:0]  in_chan = '0;
    logic [63:0] alpha_flat;
    logic        out_valid;
    logic signed [7:0] out_data;

    int alpha_w [4];
    int n_chk = 0;
    int n_fail = 0;
    int mh [3];
    int exp_q [$];
    string tag_q [$];
    bit mon_en = 1'b0;
    int lfsr = 32'h1ace;

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < 4; c++) alpha_flat[c*16 +: 16] = 16'(alpha_w[c]);
    end

    skew_farrow_corrector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_chan    (in_chan),
        .alpha_flat (alpha_flat),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic real wgt(input int k, input int j);
        case (k*4 + j)
            0: return 1.0;
            4: return -11.0/6.0;  5: return 3.0;   6: return -1.5; 7: return 1.0/3.0;
            8: return 1.0;        9: return -2.5;  10: return 2.0; 11: return -0.5;
            12: return -1.0/6.0;  13: return 0.5;  14: return -0.5; 15: return 1.0/6.0;
            default: return 0.0;
        endcase
    endfunction

    function automatic longint qz(input real v);
        real s;
        s = v * 32768.0;
        if (s >= 0.0) return longint'($floor(s + 0.5));
        return -longint'($floor(-s + 0.5));
    endfunction

    // R4, R5, R6 computed from the requirement text
    function automatic int model(input int x0, input int x1, input int x2, input int x3, input int al);
        longint xs [4];
        longint s  [4];
        longint a;
        longint y;
        xs[0] = x0; xs[1] = x1; xs[2] = x2; xs[3] = x3;
        for (int k = 0; k < 4; k++) begin
            s[k] = 0;
            for (int j = 0; j < 4; j++) s[k] += qz(wgt(k, j)) * xs[j];
        end
        a = s[3];
        for (int k = 2; k >= 0; k--) a = s[k] + ((a * longint'(al)) >>> 15);
        y = (a + 16384) >>> 15;
        if (y > 127)  y = 127;
        if (y < -128) y = -128;
        return int'(y);
    endfunction

    task automatic send(input int x, input int ch, input string tag);
        int al;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(x);
        in_chan  = 2'(ch);
        al = (ch == 0) ? 0 : alpha_w[ch];
        exp_q.push_back(model(x, mh[0], mh[1], mh[2], al));
        tag_q.push_back(tag);
        mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = x;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain(input string tag);
        idle(8);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    function automatic int next_rand();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
        return (lfsr & 255) - 128;
    endfunction

    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected out_valid", 1, 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_data == 8'(e), t, out_data, e);
            end
        end
    end

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
        chk(out_data == 8'sd0, "R9 data in reset", out_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        idle(2);
        chk(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
        chk(out_data == 8'sd0, "R9 data after reset", out_data, 0);
        send(100, 1, "R9 first sample zero history");
        drain("R9 drain");
    endtask

    task automatic test_latency();
        int seen;
        send(37, 2, "R1 latency sample");
        seen = 0;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid) seen = c;
            if (c < 4) chk(out_valid == 1'b0, "R1 early valid", out_valid, 0);
        end
        chk(seen == 4, "R1 latency", seen, 4);
    endtask

    task automatic test_reference();
        alpha_w[0] = 16384;
        for (int i = 0; i < 6; i++) begin
            send(next_rand(), 0, "R2 reference passthrough");
        end
        drain("R2 drain");
    endtask

    task automatic test_interleave();
        alpha_w[1] = -655; alpha_w[2] = 328; alpha_w[3] = -492;
        for (int i = 0; i < 64; i++) send(next_rand(), i % 4, "R3/R4/R5 interleaved");
        drain("R3 drain");
        alpha_w[1] = 20000; alpha_w[2] = -30000; alpha_w[3] = 32767;
        for (int i = 0; i < 32; i++) send(next_rand(), (i * 3) % 4, "R4/R5 large skew");
        drain("R4 drain");
    endtask

    task automatic test_gaps();
        for (int i = 0; i < 24; i++) begin
            send(next_rand(), i % 4, "R7 with gaps");
            idle(i % 3);
        end
        drain("R7 drain");
    endtask

    task automatic test_saturate();
        alpha_w[2] = 16384;
        send(-128, 0, "R6 setup"); send(-128, 1, "R6 setup");
        send(127, 3, "R6 setup");  send(127, 2, "R6 clamp high");
        send(127, 0, "R6 setup");  send(127, 1, "R6 setup");
        send(-128, 3, "R6 setup"); send(-128, 2, "R6 clamp low");
        drain("R6 drain");
        // last result clamped low; it must stay while idle
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0 && out_data == -8'sd128, "R8 hold after idle", out_data, -128);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        alpha_w[0] = 0; alpha_w[1] = 0; alpha_w[2] = 0; alpha_w[3] = 0;
        mh[0] = 0; mh[1] = 0; mh[2] = 0;
        test_reset();
        test_latency();
        test_reference();
        test_interleave();
        test_gaps();
        test_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule